// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block watches the two wires of an I2C bus as a slave device. It re-times both lines into the local clock and detects start and stop conditions. After each start it collects the first byte, which holds a 7-bit address and a direction bit. It then decides whether the byte is meant for this device: either the address equals a programmable own address, or the byte is the general call. On a match it drives SDA low for the acknowledge clock. On the falling edge of that clock it raises a one-cycle interrupt, clears its pending flag and holds SCL low. The hold lasts until software releases the pending state.

Software uses a small configuration port. That port loads the own address and an address-mode bit. A two-bit command written through it can also return the block to the slave-receiver state, which ends any transaction in progress. Receiving data bytes after the address, 10-bit addressing and master operation are left to other logic.

Top module: `i2c_addr_slave`

## Requirements
- R1: After reset, the pending flag reads 1. Busy, transmit, general-call, interrupt, SDA pull and SCL hold all read 0.
- R2: A start condition (SDA falls while SCL is high) sets the busy status. A stop condition (SDA rises while SCL is high) clears it.
- R3: When the first byte after a start carries the own address in bits 7..1 (first bit sent is bit 7), SDA is pulled low from the eighth SCL falling edge until the ninth SCL falling edge.
- R4: The byte 0x00 (address 0, direction 0) is a general call. It is acknowledged and sets the general-call status to 1. An own-address match leaves that status 0, and the byte 0x01 is not a general call.
- R5: On an acknowledged byte, the ninth SCL falling edge produces exactly one single-cycle interrupt pulse and clears the pending flag to 0.
- R6: While the pending flag is 0, SCL is held low. A pulse on the pending-release input sets the flag back to 1 and lets SCL go.
- R7: A byte that matches neither the own address nor the general call gets no SDA pull, no interrupt and no change of the pending flag.
- R8: On a match, the received direction bit (bit 0) is copied to the transmit status, where 1 means the slave will transmit.
- R9: When the address-mode bit is 1, no byte is acknowledged and no interrupt is raised, including the general call.
- R10: A configuration write with command 2'b10 returns the block to slave receiver: pending 1, transmit 0, busy 0, SCL released. A write with any other command code only loads the address and mode, and leaves the pending flag unchanged.
- R11: A repeated start in the middle of a byte discards the bits collected so far and starts a fresh address capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | SCL line as seen on the bus |
| sda_in | input | 1 | SDA line as seen on the bus |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cmd | input | 2 | Command code; 2'b10 reinitialises to slave receiver |
| cfg_own | input | 7 | Own 7-bit address to load |
| cfg_alt | input | 1 | Address-mode bit; 0 = normal address recognition |
| pend_release | input | 1 | Pulse that sets the pending flag back to 1 |
| sda_pull | output | 1 | Open-drain enable: 1 drives SDA low |
| scl_hold | output | 1 | Open-drain enable: 1 holds SCL low |
| irq | output | 1 | Single-cycle interrupt request |
| st_busy | output | 1 | Bus busy status |
| st_trx | output | 1 | Transmit status from the direction bit |
| st_pend | output | 1 | Pending flag (0 = waiting for software) |
| st_gcall | output | 1 | Last match was a general call |

## Verification
The embedded assertions watch, on every cycle, that busy only rises after a detected start, and that SDA is only pulled while the bus is busy. They also check that every interrupt follows the acknowledge state and leaves the flag cleared with SCL held, that a release out of the hold always restores the pending flag, and that the bit counter never passes eight. Only the bench's bus scenarios can show which byte values are acknowledged. The same applies to the general-call and direction-bit status, the effect of the address-mode bit, recovery through the initialise command, and the restart of capture after a repeated start.

// File: rtl/i2c_as_pkg.sv
// Package: shared types and constants for the I2C slave address recognizer.
// Assumes nothing beyond IEEE 1800-2017.
package i2c_as_pkg;

    // Sequencer states of the slave front end.
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,   // waiting for a start condition
        S_ADDR = 3'd1,   // collecting the first byte
        S_ACK  = 3'd2,   // matched: pulling SDA through the ninth clock
        S_NACK = 3'd3,   // no match: letting the ninth clock pass
        S_HOLD = 3'd4,   // interrupt raised, SCL stretched until release
        S_DONE = 3'd5    // released; waiting for stop or new start
    } slv_state_t;

    // Configuration command that reinitialises to slave receiver.
    localparam logic [1:0] CMD_INIT = 2'b10;

endpackage

// File: rtl/i2c_as_sync.sv
// Module: multi-flop synchroniser for one asynchronous bus line.
// Assumes the line idles high, so the chain resets to 1.
module i2c_as_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_in};
    end

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/i2c_as_cond.sv
// Module: bus condition detector. Produces one-cycle SCL edge strobes and
// start/stop strobes from already synchronised SCL and SDA.
// Assumes both inputs come from synchronisers of equal depth.
module i2c_as_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_d;
    logic sda_d;

    // Keep the previous sample of each line for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    // SCL must be high in both samples so simultaneous edges are not taken.
    assign start_det = sda_d & ~sda_s & scl_s & scl_d;
    assign stop_det  = ~sda_d & sda_s & scl_s & scl_d;
endmodule

// File: rtl/i2c_as_shift.sv
// Module: first-byte shift register with bit counter, MSB first.
// Assumes shift_en pulses once per SCL rising edge during capture.
module i2c_as_shift #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            shift_en,
    input  logic            bit_in,
    output logic [BITS-1:0] rx_byte,
    output logic            full
);
    localparam int CNT_W = $clog2(BITS + 1);

    logic [CNT_W-1:0] cnt;

    // Collect bits and count them; clear restarts the byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rx_byte <= '0;
            cnt     <= '0;
        end else if (shift_en && !full) begin
            rx_byte <= {rx_byte[BITS-2:0], bit_in};
            cnt     <= cnt + 1'b1;
        end
    end

    assign full = (cnt == CNT_W'(BITS));

    // R3: the counter never passes the byte length.
    a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(BITS));
endmodule

// File: rtl/i2c_as_match.sv
// Module: address comparator. Flags an own-address hit and a general call.
// Assumes rx_byte holds address in the upper bits and direction in bit 0.
module i2c_as_match #(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W:0]   rx_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              alt_mode,
    output logic              own_hit,
    output logic              gc_hit
);
    // Compare only in normal address mode.
    always_comb begin
        own_hit = !alt_mode && (rx_byte[ADDR_W:1] == own_addr);
        gc_hit  = !alt_mode && (rx_byte == '0);
    end
endmodule

// File: rtl/i2c_addr_slave.sv
// Module: I2C slave address recognizer (top). Synchronises the bus lines,
// captures the first byte after each start, acknowledges its own address or
// the general call, interrupts on the ninth SCL falling edge and stretches
// SCL until software releases the pending flag.
// Assumes the enables drive external open-drain pads.
module i2c_addr_slave
    import i2c_as_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_cmd,
    input  logic [ADDR_W-1:0] cfg_own,
    input  logic              cfg_alt,
    input  logic              pend_release,
    output logic              sda_pull,
    output logic              scl_hold,
    output logic              irq,
    output logic              st_busy,
    output logic              st_trx,
    output logic              st_pend,
    output logic              st_gcall
);
    localparam int BYTE_W = ADDR_W + 1;

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] rx_byte;
    logic byte_full, own_hit, gc_hit;
    logic [ADDR_W-1:0] own_q;
    logic alt_q, gc_pend, ninth_hi;
    logic init_cmd;
    slv_state_t state;

    i2c_as_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
        .clk(clk), .rst_n(rst_n), .d_in(scl_in), .q_out(scl_s));
    i2c_as_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
        .clk(clk), .rst_n(rst_n), .d_in(sda_in), .q_out(sda_s));

    i2c_as_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det));

    assign init_cmd = cfg_we && (cfg_cmd == CMD_INIT);

    i2c_as_shift #(.BITS(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .clear(start_det || init_cmd),
        .shift_en((state == S_ADDR) && scl_rise),
        .bit_in(sda_s), .rx_byte(rx_byte), .full(byte_full));

    i2c_as_match #(.ADDR_W(ADDR_W)) u_match (
        .rx_byte(rx_byte), .own_addr(own_q), .alt_mode(alt_q),
        .own_hit(own_hit), .gc_hit(gc_hit));

    // Configuration registers: own address and address-mode bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q <= '0;
            alt_q <= 1'b0;
        end else if (cfg_we) begin
            own_q <= cfg_own;
            alt_q <= cfg_alt;
        end
    end

    // Slave sequencer with status and interrupt generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            st_busy  <= 1'b0;
            st_pend  <= 1'b1;
            st_trx   <= 1'b0;
            st_gcall <= 1'b0;
            gc_pend  <= 1'b0;
            ninth_hi <= 1'b0;
            irq      <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (init_cmd) begin
                state    <= S_IDLE;
                st_busy  <= 1'b0;
                st_pend  <= 1'b1;
                st_trx   <= 1'b0;
                st_gcall <= 1'b0;
                ninth_hi <= 1'b0;
            end else if (start_det) begin
                state    <= S_ADDR;
                st_busy  <= 1'b1;
                ninth_hi <= 1'b0;
            end else if (stop_det) begin
                state   <= S_IDLE;
                st_busy <= 1'b0;
            end else begin
                if (pend_release) st_pend <= 1'b1;
                case (state)
                    S_ADDR: begin
                        if (byte_full && scl_fall) begin
                            ninth_hi <= 1'b0;
                            gc_pend  <= gc_hit;
                            state    <= (own_hit || gc_hit) ? S_ACK : S_NACK;
                        end
                    end
                    S_ACK: begin
                        if (scl_rise) begin
                            ninth_hi <= 1'b1;
                        end else if (scl_fall && ninth_hi) begin
                            state    <= S_HOLD;
                            irq      <= 1'b1;
                            st_pend  <= 1'b0;
                            st_trx   <= rx_byte[0];
                            st_gcall <= gc_pend;
                        end
                    end
                    S_NACK: begin
                        if (scl_rise) begin
                            ninth_hi <= 1'b1;
                        end else if (scl_fall && ninth_hi) begin
                            state <= S_IDLE;
                        end
                    end
                    S_HOLD: begin
                        if (pend_release) state <= S_DONE;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull = (state == S_ACK);
    assign scl_hold = ~st_pend;

    // R2: busy only rises after a detected start.
    a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_busy) |-> $past(start_det));
    // R3: SDA is only pulled during a busy bus.
    a_r3_pull_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> st_busy);
    // R5: an interrupt leaves the flag cleared and SCL held.
    a_r5_irq_clears_pend: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!st_pend && scl_hold));
    // R7: an interrupt is only raised out of the acknowledge state.
    a_r7_irq_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(state == S_ACK));
    // R6: release during the hold restores the pending flag.
    a_r6_release_restores: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_release && state == S_HOLD && !start_det) |=> st_pend);
endmodule

// File: tb/i2c_addr_slave_tb.sv
`timescale 1ns/1ps
module i2c_addr_slave_tb;
    localparam int H = 20;                  // half SCL period in clocks
    localparam logic [6:0] OWN = 7'h3A;
    // Vector fields: [10:3] first byte, [2] ack, [1] general call, [0] trx
    localparam int NV = 6;
    localparam logic [10:0] VEC [NV] = '{
        {8'h74, 1'b1, 1'b0, 1'b0},
        {8'h75, 1'b1, 1'b0, 1'b1},
        {8'h00, 1'b1, 1'b1, 1'b0},
        {8'h01, 1'b0, 1'b0, 1'b0},
        {8'h76, 1'b0, 1'b0, 1'b0},
        {8'hF4, 1'b0, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic cfg_we = 1'b0, cfg_alt = 1'b0, pend_release = 1'b0;
    logic [1:0] cfg_cmd = 2'b00;
    logic [6:0] cfg_own = '0;
    logic sda_pull, scl_hold, irq, st_busy, st_trx, st_pend, st_gcall;
    logic scl_bus, sda_bus;
    int checks = 0, errors = 0, irq_cnt = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    assign scl_bus = m_scl & ~scl_hold;
    assign sda_bus = m_sda & ~sda_pull;

    i2c_addr_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
        .cfg_we(cfg_we), .cfg_cmd(cfg_cmd), .cfg_own(cfg_own),
        .cfg_alt(cfg_alt), .pend_release(pend_release),
        .sda_pull(sda_pull), .scl_hold(scl_hold), .irq(irq),
        .st_busy(st_busy), .st_trx(st_trx), .st_pend(st_pend),
        .st_gcall(st_gcall));

    always @(posedge clk) if (rst_n && irq) irq_cnt <= irq_cnt + 1;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] cmd, input logic [6:0] a,
                             input logic alt);
        cfg_cmd = cmd; cfg_own = a; cfg_alt = alt; cfg_we = 1'b1;
        tick(1);
        cfg_we = 1'b0;
        tick(3);
    endtask

    task automatic release_pend();
        pend_release = 1'b1;
        tick(1);
        pend_release = 1'b0;
        tick(3);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b0; tick(H);
        m_scl = 1'b0; tick(5);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b1; tick(H);
    endtask

    task automatic bus_bit(input logic b);
        m_sda = b;    tick(H);
        m_scl = 1'b1; tick(H);
        m_scl = 1'b0; tick(5);
    endtask

    // Sends a byte and the ninth clock; reports pull before and during it.
    task automatic bus_byte(input logic [7:0] b, output logic pull_pre,
                            output logic acked, output int irq_early);
        for (int i = 7; i >= 0; i--) bus_bit(b[i]);
        m_sda = 1'b1; tick(H);
        pull_pre = sda_pull;
        m_scl = 1'b1; tick(H/2);
        acked = ~sda_bus;
        irq_early = irq_cnt;
        tick(H/2);
        m_scl = 1'b0; tick(10);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic pre, ack;
        int i0, e;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        // R1: reset state
        check("R1", "st_pend", st_pend, 1);
        check("R1", "st_busy", st_busy, 0);
        check("R1", "st_trx", st_trx, 0);
        check("R1", "st_gcall", st_gcall, 0);
        check("R1", "sda_pull", sda_pull, 0);
        check("R1", "scl_hold", scl_hold, 0);
        check("R1", "irq_cnt", irq_cnt, 0);

        cfg_write(2'b10, OWN, 1'b0);

        // Vector table walk: R2 R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            logic [7:0] b;
            logic xa, xg, xt;
            b = VEC[v][10:3]; xa = VEC[v][2]; xg = VEC[v][1]; xt = VEC[v][0];
            bus_start();
            check("R2", "busy after start", st_busy, 1);
            i0 = irq_cnt;
            bus_byte(b, pre, ack, e);
            check("R3", "pull before ninth clock", pre, xa);
            check("R3/R7", "ack on bus", ack, xa);
            check("R5", "no irq before ninth fall", e - i0, 0);
            check("R5/R7", "irq pulses", irq_cnt - i0, xa);
            check("R5/R7", "pending", st_pend, !xa);
            check("R6", "scl hold", scl_hold, xa);
            if (xa) begin
                check("R8", "trx", st_trx, xt);
                check("R4", "gcall", st_gcall, xg);
                release_pend();
                check("R6", "pending after release", st_pend, 1);
                check("R6", "hold after release", scl_hold, 0);
            end
            bus_stop();
            check("R2", "busy after stop", st_busy, 0);
        end

        // R9: address-mode bit 1 suppresses all recognition
        cfg_write(2'b00, OWN, 1'b1);
        bus_start();
        i0 = irq_cnt;
        bus_byte(8'h74, pre, ack, e);
        check("R9", "own addr ack in alt mode", ack, 0);
        bus_stop();
        bus_start();
        bus_byte(8'h00, pre, ack, e);
        check("R9", "gcall ack in alt mode", ack, 0);
        check("R9", "irq in alt mode", irq_cnt - i0, 0);
        check("R9", "pending in alt mode", st_pend, 1);
        bus_stop();

        // R10: non-init write keeps pending, init write restores it
        cfg_write(2'b10, OWN, 1'b0);
        bus_start();
        bus_byte(8'h75, pre, ack, e);
        check("R10", "trx before init", st_trx, 1);
        cfg_write(2'b00, OWN, 1'b0);
        check("R10", "pending after non-init write", st_pend, 0);
        check("R10", "hold after non-init write", scl_hold, 1);
        cfg_write(2'b10, OWN, 1'b0);
        check("R10", "pending after init", st_pend, 1);
        check("R10", "hold after init", scl_hold, 0);
        check("R10", "trx after init", st_trx, 0);
        check("R10", "busy after init", st_busy, 0);
        bus_stop();

        // R11: repeated start mid-byte restarts capture
        bus_start();
        bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
        i0 = irq_cnt;
        bus_start();
        bus_byte(8'h74, pre, ack, e);
        check("R11", "ack after repeated start", ack, 1);
        check("R11", "irq after repeated start", irq_cnt - i0, 1);
        release_pend();
        bus_stop();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule